// File: doc/BRIEF.md
# Flash bank operation arbiter

This block sits in front of a multi-bank NOR-style flash array and decides, for every incoming request, whether the array may service it. It turns a word address into a bank number and a global erase-block number. The parameter area, which holds four small blocks, can sit at the low end or the high end of the map, and a static configuration input selects which. The block also tracks the single program or erase operation the array may run at a time, along with its suspend state and an optional program that runs nested inside a suspended erase.

Each accepted request gets a registered response one cycle later. The response says whether the request was granted and, for reads, whether the array would return status instead of data. It also gives the decoded bank and block. Rejections set a sticky error flag that only an explicit clear request resets. A separate completion strobe from the timing engine ends whichever operation is actually running.

Top module: `flash_bank_arbiter`

## Requirements
- R1: With `param_top`=0, words 0..0xFFFF form blocks 0..3 (16K words each, selected by address bits 15:14), and every 64K-word block above them is numbered (address bits 22:16) + 3. The bank is address bits 22:19.
- R2: With `param_top`=1, the topmost 64K words form blocks 127..130 (127 + bits 15:14), and every other 64K-word block is numbered by address bits 22:16.
- R3: Opcodes are 0 read, 1 program, 2 erase, 3 suspend, 4 resume, 5 clear error, 6 read-mode set, 7 reserved. A program or erase is rejected while any program or erase is active, except for the nested program allowed by R5.
- R4: A read is granted while an operation runs. It is flagged `rsp_rd_status`=1 when it targets the bank of a running (unsuspended) primary operation or of a running nested program, and 0 otherwise.
- R5: While an erase is suspended, a read or a program to any block other than the erased block is granted, and either one to the erased block is rejected. Only one nested program may run at a time.
- R6: While a program is suspended, a read of the exact word being programmed is rejected, reads of all other words are granted, and a new program is rejected.
- R7: Suspend is granted only for a running primary operation with no nested program. Resume is granted only for a suspended primary with no nested program. All other suspend and resume requests are rejected.
- R8: Any rejected request sets `st_err`. It stays set through later granted requests until a clear-error request (opcode 5) resets it.
- R9: After reset the read mode is asynchronous (`st_sync_rd`=0). Opcode 6 sets it to address bit 0.
- R10: `req_ready` is low in any cycle where `eng_done` is high. `eng_done` completes the nested program if one runs, otherwise it completes the running primary operation.
- R11: The response appears exactly one cycle after acceptance, and opcode 7 is always rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| param_top | input | 1 | 1 places the parameter blocks at the top of the map |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 3 | Operation code (see R3) |
| req_addr | input | 23 | Word address |
| eng_done | input | 1 | Timing engine finished the running operation |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Request granted |
| rsp_rd_status | output | 1 | Granted read returns status instead of array data |
| rsp_bank | output | 4 | Decoded bank of the request |
| rsp_blk | output | 8 | Decoded global block of the request |
| st_busy | output | 1 | The engine is running an operation |
| st_erase_susp | output | 1 | An erase is suspended |
| st_prog_susp | output | 1 | A primary program is suspended |
| st_err | output | 1 | Sticky rejection flag |
| st_sync_rd | output | 1 | Read mode is synchronous |

## Verification
The hardest state to reach is a program running nested inside a suspended erase. While it runs, the block must route reads to the shared bank to status, refuse both suspend and resume, and, once the nested program completes, let the erase resume. The stimulus gets there in order: it starts an erase, suspends it, probes the erased block and a sibling block, starts a program in another block of the same bank, and then issues the forbidden suspend and resume. It then pulses completion twice, checking that the first pulse retires only the nested program.

// File: rtl/flash_arb_pkg.sv
package flash_arb_pkg;
  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_PROG   = 3'd1,
    OP_ERASE  = 3'd2,
    OP_SUSP   = 3'd3,
    OP_RESUME = 3'd4,
    OP_CLRERR = 3'd5,
    OP_RDCFG  = 3'd6,
    OP_RSVD   = 3'd7
  } op_e;
endpackage

// File: rtl/fba_addr_map.sv
module fba_addr_map #(
  parameter int ADDR_W  = 23,
  parameter int BANK_W  = 4,
  parameter int MAIN_W  = 16,
  parameter int PARAM_W = 14,
  parameter int BLK_W   = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              param_top,
  output logic [BANK_W-1:0] bank,
  output logic [BLK_W-1:0]  blk
);
  localparam int MI_W   = ADDR_W - MAIN_W;
  localparam int PI_W   = MAIN_W - PARAM_W;
  localparam int NPARAM = 1 << PI_W;

  logic [MI_W-1:0] mi;
  logic [PI_W-1:0] pi;

  assign mi   = addr[ADDR_W-1:MAIN_W];
  assign pi   = addr[MAIN_W-1:PARAM_W];
  assign bank = addr[ADDR_W-1 -: BANK_W];

  always_comb begin
    if (param_top) begin
      if (mi == {MI_W{1'b1}}) blk = BLK_W'(mi) + BLK_W'(pi);
      else                    blk = BLK_W'(mi);
    end else begin
      if (mi == '0) blk = BLK_W'(pi);
      else          blk = BLK_W'(mi) + BLK_W'(NPARAM - 1);
    end
  end
endmodule

// File: rtl/fba_rules.sv
module fba_rules
  import flash_arb_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int BANK_W = 4,
  parameter int BLK_W  = 8
) (
  input  logic              acc,
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  input  logic [BLK_W-1:0]  blk,
  input  logic              done,
  input  logic              p_act,
  input  logic              p_erase,
  input  logic              p_susp,
  input  logic [ADDR_W-1:0] p_addr,
  input  logic [BANK_W-1:0] p_bank,
  input  logic [BLK_W-1:0]  p_blk,
  input  logic              n_act,
  input  logic [BANK_W-1:0] n_bank,
  input  logic              err,
  input  logic              sync,
  output logic              p_act_d,
  output logic              p_erase_d,
  output logic              p_susp_d,
  output logic              p_ld,
  output logic              n_act_d,
  output logic              n_ld,
  output logic              err_d,
  output logic              sync_d,
  output logic              grant,
  output logic              rd_stat
);
  logic reject;
  logic es_hold, ps_hold;

  assign es_hold = p_act & p_susp & p_erase;
  assign ps_hold = p_act & p_susp & ~p_erase;

  always_comb begin
    p_act_d   = p_act;
    p_erase_d = p_erase;
    p_susp_d  = p_susp;
    n_act_d   = n_act;
    err_d     = err;
    sync_d    = sync;
    p_ld      = 1'b0;
    n_ld      = 1'b0;
    reject    = 1'b0;
    rd_stat   = 1'b0;

    if (done) begin
      if (n_act)                n_act_d = 1'b0;
      else if (p_act && !p_susp) p_act_d = 1'b0;
    end

    if (acc) begin
      unique case (op)
        OP_READ: begin
          if ((ps_hold && addr == p_addr) || (es_hold && blk == p_blk)) reject = 1'b1;
          else rd_stat = (n_act && bank == n_bank) ||
                         (p_act && !p_susp && bank == p_bank);
        end
        OP_PROG: begin
          if (!p_act) begin
            p_act_d = 1'b1; p_erase_d = 1'b0; p_susp_d = 1'b0; p_ld = 1'b1;
          end else if (es_hold && !n_act && blk != p_blk) begin
            n_act_d = 1'b1; n_ld = 1'b1;
          end else reject = 1'b1;
        end
        OP_ERASE: begin
          if (!p_act) begin
            p_act_d = 1'b1; p_erase_d = 1'b1; p_susp_d = 1'b0; p_ld = 1'b1;
          end else reject = 1'b1;
        end
        OP_SUSP: begin
          if (p_act && !p_susp && !n_act) p_susp_d = 1'b1;
          else reject = 1'b1;
        end
        OP_RESUME: begin
          if (p_act && p_susp && !n_act) p_susp_d = 1'b0;
          else reject = 1'b1;
        end
        OP_CLRERR: err_d = 1'b0;
        OP_RDCFG:  sync_d = addr[0];
        default:   reject = 1'b1;
      endcase
      if (reject) err_d = 1'b1;
    end
    grant = acc & ~reject;
  end
endmodule

// File: rtl/flash_bank_arbiter.sv
module flash_bank_arbiter
  import flash_arb_pkg::*;
#(
  parameter int ADDR_W  = 23,
  parameter int BANK_W  = 4,
  parameter int MAIN_W  = 16,
  parameter int PARAM_W = 14,
  parameter int BLK_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              param_top,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              eng_done,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic              rsp_rd_status,
  output logic [BANK_W-1:0] rsp_bank,
  output logic [BLK_W-1:0]  rsp_blk,
  output logic              st_busy,
  output logic              st_erase_susp,
  output logic              st_prog_susp,
  output logic              st_err,
  output logic              st_sync_rd
);
  logic [1:0]        rst_q;
  logic              rst_i_n;
  logic              acc;
  logic [BANK_W-1:0] bank;
  logic [BLK_W-1:0]  blk;

  logic              p_act, p_erase, p_susp, n_act, err, sync;
  logic [ADDR_W-1:0] p_addr;
  logic [BANK_W-1:0] p_bank, n_bank;
  logic [BLK_W-1:0]  p_blk;

  logic p_act_d, p_erase_d, p_susp_d, p_ld, n_act_d, n_ld, err_d, sync_d;
  logic grant, rd_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i_n = rst_q[1];

  assign req_ready = rst_i_n & ~eng_done;
  assign acc       = req_valid & req_ready;

  fba_addr_map #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .MAIN_W(MAIN_W),
    .PARAM_W(PARAM_W), .BLK_W(BLK_W)
  ) u_map (
    .addr(req_addr), .param_top(param_top), .bank(bank), .blk(blk)
  );

  fba_rules #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .BLK_W(BLK_W)) u_rules (
    .acc(acc), .op(op_e'(req_op)), .addr(req_addr), .bank(bank), .blk(blk),
    .done(eng_done & rst_i_n),
    .p_act(p_act), .p_erase(p_erase), .p_susp(p_susp), .p_addr(p_addr),
    .p_bank(p_bank), .p_blk(p_blk), .n_act(n_act), .n_bank(n_bank),
    .err(err), .sync(sync),
    .p_act_d(p_act_d), .p_erase_d(p_erase_d), .p_susp_d(p_susp_d), .p_ld(p_ld),
    .n_act_d(n_act_d), .n_ld(n_ld), .err_d(err_d), .sync_d(sync_d),
    .grant(grant), .rd_stat(rd_stat)
  );

  // control state
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      p_act   <= 1'b0;
      p_erase <= 1'b0;
      p_susp  <= 1'b0;
      n_act   <= 1'b0;
      err     <= 1'b0;
      sync    <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      p_act   <= p_act_d;
      p_erase <= p_erase_d;
      p_susp  <= p_susp_d;
      n_act   <= n_act_d;
      err     <= err_d;
      sync    <= sync_d;
      rsp_valid <= acc;
    end
  end

  // datapath registers with explicit load enables
  always_ff @(posedge clk) begin
    if (p_ld) begin
      p_addr <= req_addr;
      p_bank <= bank;
      p_blk  <= blk;
    end
    if (n_ld) n_bank <= bank;
    if (acc) begin
      rsp_grant     <= grant;
      rsp_rd_status <= rd_stat;
      rsp_bank      <= bank;
      rsp_blk       <= blk;
    end
  end

  assign st_busy       = n_act | (p_act & ~p_susp);
  assign st_erase_susp = p_act & p_susp & p_erase;
  assign st_prog_susp  = p_act & p_susp & ~p_erase;
  assign st_err        = err;
  assign st_sync_rd    = sync;
endmodule

// File: rtl/flash_bank_arbiter_chk.sv
module flash_bank_arbiter_chk #(
  parameter int ADDR_W = 23,
  parameter int BANK_W = 4,
  parameter int BLK_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_op,
  input logic              eng_done,
  input logic              rsp_valid,
  input logic              rsp_grant,
  input logic              rsp_rd_status,
  input logic              st_erase_susp,
  input logic              st_prog_susp,
  input logic              st_err,
  input logic              st_sync_rd
);
  // R10
  done_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |-> !req_ready);

  // R11
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready));

  // R8
  reject_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_grant) |-> st_err);

  // R4
  status_read_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_rd_status && rsp_valid |-> rsp_grant);

  // R7
  one_suspend_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_erase_susp, st_prog_susp}));

  // R9
  mode_change_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_sync_rd) |-> (rsp_valid && rsp_grant));

  // R11
  reserved_op_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 3'd7) |=> (rsp_valid && !rsp_grant));
endmodule

bind flash_bank_arbiter flash_bank_arbiter_chk #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .BLK_W(BLK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .eng_done(eng_done), .rsp_valid(rsp_valid),
  .rsp_grant(rsp_grant), .rsp_rd_status(rsp_rd_status),
  .st_erase_susp(st_erase_susp), .st_prog_susp(st_prog_susp),
  .st_err(st_err), .st_sync_rd(st_sync_rd)
);

// File: tb/sim_flash_bank_arbiter.sv
module sim_flash_bank_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        param_top = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = 3'd0;
  logic [22:0] req_addr = '0;
  logic        eng_done = 1'b0;
  logic        rsp_valid, rsp_grant, rsp_rd_status;
  logic [3:0]  rsp_bank;
  logic [7:0]  rsp_blk;
  logic        st_busy, st_erase_susp, st_prog_susp, st_err, st_sync_rd;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct packed {
    logic       grant;
    logic       rdst;
    logic [3:0] bank;
    logic [7:0] blk;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  flash_bank_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .param_top(param_top), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
    .eng_done(eng_done), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
    .rsp_rd_status(rsp_rd_status), .rsp_bank(rsp_bank), .rsp_blk(rsp_blk),
    .st_busy(st_busy), .st_erase_susp(st_erase_susp),
    .st_prog_susp(st_prog_susp), .st_err(st_err), .st_sync_rd(st_sync_rd)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // driver: one request per call, expected response pushed to the scoreboard
  task automatic send(input logic [2:0] op, input logic [22:0] a,
                      input logic g, input logic rs, input logic [3:0] bk,
                      input logic [7:0] bl, input string tag);
    exp_t e;
    @(negedge clk);
    e.grant = g; e.rdst = rs; e.bank = bk; e.blk = bl;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    req_op = op; req_addr = a; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic done_pulse(input string tag);
    @(negedge clk);
    eng_done = 1'b1;
    #1;
    chk(req_ready == 1'b0, tag, "ready during done", int'(req_ready), 0);
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  // monitor: compare each response with the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11", "unexpected response", 1, 0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({rsp_grant, rsp_rd_status, rsp_bank, rsp_blk} == e, t, "response",
            int'({rsp_grant, rsp_rd_status, rsp_bank, rsp_blk}), int'(e));
      end
    end
  end

  initial begin
    #2_000_000;
    chk(1'b0, "R11", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({st_busy, st_erase_susp, st_prog_susp, st_err} == 4'b0, "R3", "reset status",
        int'({st_busy, st_erase_susp, st_prog_susp, st_err}), 0);
    chk(st_sync_rd == 1'b0, "R9", "async read after reset", int'(st_sync_rd), 0);
    chk(req_ready == 1'b1, "R10", "ready after reset", int'(req_ready), 1);

    // bottom parameter layout (R1)
    send(3'd0, 23'h000000, 1, 0, 4'd0,  8'd0,   "R1");
    send(3'd0, 23'h00C000, 1, 0, 4'd0,  8'd3,   "R1");
    send(3'd0, 23'h010000, 1, 0, 4'd0,  8'd4,   "R1");
    send(3'd0, 23'h7FFFFF, 1, 0, 4'd15, 8'd130, "R1");

    // erase running in bank 4
    send(3'd2, 23'h200000, 1, 0, 4'd4, 8'd35, "R3");
    chk(st_busy == 1'b1, "R3", "busy after erase", int'(st_busy), 1);
    send(3'd0, 23'h200005, 1, 1, 4'd4, 8'd35, "R4");
    send(3'd0, 23'h400000, 1, 0, 4'd8, 8'd67, "R4");
    send(3'd1, 23'h400000, 0, 0, 4'd8, 8'd67, "R3");
    chk(st_err == 1'b1, "R8", "err after reject", int'(st_err), 1);
    send(3'd0, 23'h000000, 1, 0, 4'd0, 8'd0, "R8");
    chk(st_err == 1'b1, "R8", "err sticky", int'(st_err), 1);
    send(3'd5, 23'h000000, 1, 0, 4'd0, 8'd0, "R8");
    chk(st_err == 1'b0, "R8", "err cleared", int'(st_err), 0);

    // erase suspend
    send(3'd3, 23'h000000, 1, 0, 4'd0, 8'd0, "R7");
    chk(st_erase_susp == 1'b1 && st_busy == 1'b0, "R5", "erase suspended",
        int'({st_erase_susp, st_busy}), 2);
    send(3'd0, 23'h200010, 0, 0, 4'd4, 8'd35, "R5");
    send(3'd0, 23'h210000, 1, 0, 4'd4, 8'd36, "R5");
    send(3'd1, 23'h200100, 0, 0, 4'd4, 8'd35, "R5");
    send(3'd1, 23'h230000, 1, 0, 4'd4, 8'd38, "R5");
    chk(st_busy == 1'b1, "R5", "nested program busy", int'(st_busy), 1);
    send(3'd0, 23'h230000, 1, 1, 4'd4, 8'd38, "R4");
    send(3'd1, 23'h240000, 0, 0, 4'd4, 8'd39, "R5");
    send(3'd3, 23'h000000, 0, 0, 4'd0, 8'd0, "R7");
    send(3'd4, 23'h000000, 0, 0, 4'd0, 8'd0, "R7");
    send(3'd5, 23'h000000, 1, 0, 4'd0, 8'd0, "R8");
    done_pulse("R10");
    chk(st_erase_susp == 1'b1 && st_busy == 1'b0, "R10", "nested retired first",
        int'({st_erase_susp, st_busy}), 2);
    send(3'd4, 23'h000000, 1, 0, 4'd0, 8'd0, "R7");
    chk(st_busy == 1'b1 && st_erase_susp == 1'b0, "R7", "erase resumed",
        int'({st_busy, st_erase_susp}), 2);
    done_pulse("R10");
    chk(st_busy == 1'b0, "R10", "erase done", int'(st_busy), 0);
    send(3'd4, 23'h000000, 0, 0, 4'd0, 8'd0, "R7");
    send(3'd5, 23'h000000, 1, 0, 4'd0, 8'd0, "R8");

    // program suspend
    send(3'd1, 23'h600040, 1, 0, 4'd12, 8'd99, "R3");
    send(3'd3, 23'h000000, 1, 0, 4'd0,  8'd0,  "R7");
    chk(st_prog_susp == 1'b1, "R6", "program suspended", int'(st_prog_susp), 1);
    send(3'd0, 23'h600040, 0, 0, 4'd12, 8'd99, "R6");
    send(3'd0, 23'h600041, 1, 0, 4'd12, 8'd99, "R6");
    send(3'd1, 23'h100000, 0, 0, 4'd2,  8'd19, "R6");
    send(3'd5, 23'h000000, 1, 0, 4'd0,  8'd0,  "R8");
    send(3'd4, 23'h000000, 1, 0, 4'd0,  8'd0,  "R7");
    done_pulse("R10");
    chk(st_busy == 1'b0 && st_prog_susp == 1'b0, "R10", "program done",
        int'({st_busy, st_prog_susp}), 0);

    // read mode
    send(3'd6, 23'h000001, 1, 0, 4'd0, 8'd0, "R9");
    chk(st_sync_rd == 1'b1, "R9", "sync read set", int'(st_sync_rd), 1);
    send(3'd6, 23'h000000, 1, 0, 4'd0, 8'd0, "R9");
    chk(st_sync_rd == 1'b0, "R9", "async read restored", int'(st_sync_rd), 0);

    // top parameter layout (R2)
    param_top = 1'b1;
    send(3'd0, 23'h7F0000, 1, 0, 4'd15, 8'd127, "R2");
    send(3'd0, 23'h7FC000, 1, 0, 4'd15, 8'd130, "R2");
    send(3'd0, 23'h7EFFFF, 1, 0, 4'd15, 8'd126, "R2");
    send(3'd0, 23'h000000, 1, 0, 4'd0,  8'd0,   "R2");
    send(3'd0, 23'h010000, 1, 0, 4'd0,  8'd1,   "R2");

    // reserved opcode
    send(3'd7, 23'h000000, 0, 0, 4'd0, 8'd0, "R11");
    chk(st_err == 1'b1, "R11", "err after reserved op", int'(st_err), 1);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R11", "responses outstanding", exp_q.size(), 0);
    finish_run();
  end
endmodule